// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a 4096-bit synchronous memory with two symmetric ports, A and B, sharing one clock. Each port can read or write any word in every cycle. A single parameter sets the word width to 1, 2, 4 or 8 bits, and the depth follows so that the total stays 4096 bits. Both ports have their own enable, write enable, address, write data and read data. A per-port parameter adds a second register stage on the read data.

When both ports are enabled on the same word address in the same cycle, the block flags the collision on an active-low match output and settles it with a fixed priority that depends on the two operations. Two reads need no arbitration. A write against a read lets the writer commit; the reader gets the old word first and sees the new word on its next read. Two writes let port A commit. Port B's write is dropped for that cycle and a busy flag tells port B to retry. A retry in a later cycle without a collision commits.

Top module: `dp_collide_ram`

## Requirements
- R1: With word width DATA_W in {1, 2, 4, 8}, the depth is 4096/DATA_W words. A word written through either port is later read back unchanged through either port.
- R2: match_no_o is 0 in a cycle where a_en_i and b_en_i are both 1 and a_addr_i equals b_addr_i. In every other cycle it is 1. The output is combinational.
- R3: When both ports read the same address in one cycle, both return the stored word.
- R4: When port A writes and port B reads the same address, A's word is stored. B's read returns the previous word, and B's next read of that address returns A's word.
- R5: When port A reads and port B writes the same address, B's word is stored. A's read returns the previous word, and A's next read of that address returns B's word.
- R6: When both ports write the same address, only A's word is stored. busy_b_o is 1 in exactly the cycles where both ports write the same address, and it is combinational.
- R7: A port B write blocked under R6 and repeated in a later cycle without a collision is stored.
- R8: Read data appears one clock edge after the read with OUT_REG_x = 0, and two edges after with OUT_REG_x = 1. A port's read data holds while that port is idle or writing.
- R9: While rst_ni is 0, both read data outputs are 0, match_no_o is 1 and busy_b_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable (1 = write, 0 = read) |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable (1 = write, 0 = read) |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B read data |
| match_no_o | output | 1 | Same-address collision, active low |
| busy_b_o | output | 1 | Port B write blocked this cycle |

## Verification
The directed cases cover the four operation pairs on one address, so each priority rule can be told apart from the others. The read-after-collision sequences separate old-word from new-word ordering. A blocked-then-retried write separates a dropped B write from a queued one. Random traffic packed into eight addresses produces dense collisions, near misses with one enable low, and idle gaps. It is checked against a bench memory model with per-port latency, which exposes errors in hold behaviour, latency and the match or busy decode. Port A runs without the output register and port B with it, so both latencies are exercised.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned TOTAL_BITS = 4096;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_RR,
    CK_AW_BR,
    CK_AR_BW,
    CK_WW
  } col_kind_e;

  function automatic bit width_ok(int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8);
  endfunction
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic              a_wr_o,
  output logic              a_rd_o,
  output logic              b_wr_o,
  output logic              b_rd_o,
  output logic              match_no_o,
  output logic              busy_b_o
);
  logic      same_word;
  col_kind_e kind;

  assign same_word = a_en_i && b_en_i && (a_addr_i == b_addr_i);

  always_comb begin
    kind = CK_NONE;
    if (same_word) begin
      unique case ({a_we_i, b_we_i})
        2'b00:   kind = CK_RR;
        2'b10:   kind = CK_AW_BR;
        2'b01:   kind = CK_AR_BW;
        default: kind = CK_WW;
      endcase
    end
  end

  // Reads take the pre-write word; only a write-write loses port B's write.
  assign a_rd_o     = rst_ni && a_en_i && !a_we_i;
  assign b_rd_o     = rst_ni && b_en_i && !b_we_i;
  assign a_wr_o     = rst_ni && a_en_i && a_we_i;
  assign b_wr_o     = rst_ni && b_en_i && b_we_i && (kind != CK_WW);
  assign busy_b_o   = rst_ni && (kind == CK_WW);
  assign match_no_o = !(rst_ni && (kind != CK_NONE));

  a_r2_match_needs_both_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_no_o |-> (a_en_i && b_en_i && (a_addr_i == b_addr_i)));

  a_r6_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_o && b_wr_o) |-> (a_addr_i != b_addr_i));

  a_r6_busy_is_ww: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_b_o |-> (!match_no_o && a_wr_o && !b_wr_o && b_we_i));

  a_r3_reads_never_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && !a_we_i && b_en_i && !b_we_i) |-> (a_rd_o && b_rd_o && !busy_b_o));
endmodule

// File: rtl/dpc_mem_core.sv
module dpc_mem_core #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] a_q_o,
  output logic [DATA_W-1:0] b_q_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // Arbiter guarantees the two write strobes never share an address.
  always_ff @(posedge clk_i) begin
    if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_wr_i) mem_q[b_addr_i] <= b_wdata_i;
  end

  // Read-first: the nonblocking read returns the word before this edge's writes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q_o <= '0;
      b_q_o <= '0;
    end else begin
      if (a_rd_i) a_q_o <= mem_q[a_addr_i];
      if (b_rd_i) b_q_o <= mem_q[b_addr_i];
    end
  end

  a_r8_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_rd_i |=> $stable(a_q_o));
  a_r8_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_rd_i |=> $stable(b_q_o));
endmodule

// File: rtl/dp_collide_ram.sv
module dp_collide_ram
  import dpc_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1,
  localparam int unsigned DEPTH    = TOTAL_BITS / DATA_W,
  localparam int unsigned ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              match_no_o,
  output logic              busy_b_o
);
  if (!width_ok(DATA_W)) begin : g_bad_width
    $error("DATA_W must be 1, 2, 4 or 8");
  end

  logic              a_wr, a_rd, b_wr, b_rd;
  logic [DATA_W-1:0] a_q, b_q;

  dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (a_en_i),
    .a_we_i    (a_we_i),
    .a_addr_i  (a_addr_i),
    .b_en_i    (b_en_i),
    .b_we_i    (b_we_i),
    .b_addr_i  (b_addr_i),
    .a_wr_o    (a_wr),
    .a_rd_o    (a_rd),
    .b_wr_o    (b_wr),
    .b_rd_o    (b_rd),
    .match_no_o(match_no_o),
    .busy_b_o  (busy_b_o)
  );

  dpc_mem_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_wr_i   (a_wr),
    .a_rd_i   (a_rd),
    .a_addr_i (a_addr_i),
    .a_wdata_i(a_wdata_i),
    .b_wr_i   (b_wr),
    .b_rd_i   (b_rd),
    .b_addr_i (b_addr_i),
    .b_wdata_i(b_wdata_i),
    .a_q_o    (a_q),
    .b_q_o    (b_q)
  );

  if (OUT_REG_A) begin : g_a_oreg
    logic [DATA_W-1:0] a_pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) a_pipe_q <= '0;
      else         a_pipe_q <= a_q;
    end
    assign a_rdata_o = a_pipe_q;
  end else begin : g_a_direct
    assign a_rdata_o = a_q;
  end

  if (OUT_REG_B) begin : g_b_oreg
    logic [DATA_W-1:0] b_pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) b_pipe_q <= '0;
      else         b_pipe_q <= b_q;
    end
    assign b_rdata_o = b_pipe_q;
  end else begin : g_b_direct
    assign b_rdata_o = b_q;
  end

  always_comb begin
    if (!rst_ni) begin
      a_r9_reset_outputs: assert (a_rdata_o == '0 && b_rdata_o == '0 && match_no_o && !busy_b_o);
    end
  end
endmodule

// File: tb/tb_dp_collide_ram.sv
module tb_dp_collide_ram;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 4096 / DATA_W;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam bit OREG_A = 1'b0;
  localparam bit OREG_B = 1'b1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic [DATA_W-1:0] a_wd = '0, b_wd = '0;
  logic [DATA_W-1:0] a_rd, b_rd;
  logic              match_n, busy_b;

  int unsigned n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DATA_W-1:0] mdl [DEPTH];
  logic [DATA_W-1:0] ea1 = '0, ea2 = '0, eb1 = '0, eb2 = '0;

  always #4 clk = ~clk;

  dp_collide_ram #(.DATA_W(DATA_W), .OUT_REG_A(OREG_A), .OUT_REG_B(OREG_B)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b_rd),
    .match_no_o(match_n), .busy_b_o(busy_b)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_match(logic ae, logic be, logic [ADDR_W-1:0] aa, logic [ADDR_W-1:0] ba);
    return !(ae && be && aa == ba);
  endfunction

  function automatic logic exp_busy(logic ae, logic aw, logic be, logic bw,
                                    logic [ADDR_W-1:0] aa, logic [ADDR_W-1:0] ba);
    return ae && aw && be && bw && aa == ba;
  endfunction

  // Entered at a negedge, leaves at the next negedge.
  task automatic cyc(string req, logic ae, logic aw, logic [ADDR_W-1:0] aa, logic [DATA_W-1:0] ad,
                     logic be, logic bw, logic [ADDR_W-1:0] ba, logic [DATA_W-1:0] bd);
    logic [DATA_W-1:0] na, nb;
    logic blk;
    a_en = ae; a_we = aw; a_addr = aa; a_wd = ad;
    b_en = be; b_we = bw; b_addr = ba; b_wd = bd;
    #1;
    chk("R2", "match_no", match_n, exp_match(ae, be, aa, ba));
    chk("R6", "busy_b", busy_b, exp_busy(ae, aw, be, bw, aa, ba));
    blk = exp_busy(ae, aw, be, bw, aa, ba);
    na = (ae && !aw) ? mdl[aa] : ea1;
    nb = (be && !bw) ? mdl[ba] : eb1;
    if (ae && aw) mdl[aa] = ad;
    if (be && bw && !blk) mdl[ba] = bd;
    ea2 = ea1; ea1 = na;
    eb2 = eb1; eb1 = nb;
    @(posedge clk);
    @(negedge clk);
    chk(req, "a_rdata", a_rd, OREG_A ? ea2 : ea1);
    chk(req, "b_rdata", b_rd, OREG_B ? eb2 : eb1);
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state, with colliding writes presented
    a_en = 1; a_we = 1; b_en = 1; b_we = 1;
    #1;
    chk("R9", "a_rdata in reset", a_rd, '0);
    chk("R9", "b_rdata in reset", b_rd, '0);
    chk("R9", "match_no in reset", match_n, 1'b1);
    chk("R9", "busy_b in reset", busy_b, 1'b0);
    a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: fill every word through both ports, then read back both ways
    for (int i = 0; i < DEPTH / 2; i++)
      cyc("R1", 1, 1, ADDR_W'(i), DATA_W'(i * 7 + 3), 1, 1, ADDR_W'(i + DEPTH / 2), DATA_W'(i * 5 + 1));
    for (int i = 0; i < 16; i++)
      cyc("R1", 1, 0, ADDR_W'(i + DEPTH / 2), '0, 1, 0, ADDR_W'(i), '0);
    idle("R1"); idle("R1");

    // R3: both ports read one address
    cyc("R3", 1, 0, 9'd20, '0, 1, 0, 9'd20, '0);
    idle("R3"); idle("R3");

    // R4: A writes, B reads same address, B then rereads
    cyc("R4", 1, 1, 9'd30, 8'hA5, 1, 0, 9'd30, '0);
    cyc("R4", 0, 0, '0, '0, 1, 0, 9'd30, '0);
    idle("R4"); idle("R4");

    // R5: B writes, A reads same address, A then rereads
    cyc("R5", 1, 0, 9'd31, '0, 1, 1, 9'd31, 8'h5A);
    cyc("R5", 1, 0, 9'd31, '0, 0, 0, '0, '0);
    idle("R5"); idle("R5");

    // R6 / R7: write-write, B retries, then read back through A
    cyc("R6", 1, 1, 9'd40, 8'h11, 1, 1, 9'd40, 8'h22);
    cyc("R6", 1, 0, 9'd40, '0, 0, 0, '0, '0);
    cyc("R7", 0, 0, '0, '0, 1, 1, 9'd40, 8'h22);
    cyc("R7", 1, 0, 9'd40, '0, 0, 0, '0, '0);
    idle("R7"); idle("R7");

    // R8: writes on both ports leave the read data held
    cyc("R8", 1, 1, 9'd50, 8'h77, 1, 1, 9'd51, 8'h88);
    idle("R8"); idle("R8");

    // R8 / R2 / R6: dense random traffic on eight addresses
    for (int n = 0; n < 4000; n++) begin
      logic ae, aw, be, bw;
      ae = ($urandom_range(0, 3) != 0);
      be = ($urandom_range(0, 3) != 0);
      aw = $urandom_range(0, 1);
      bw = $urandom_range(0, 1);
      cyc("R8", ae, aw, ADDR_W'($urandom_range(0, 7)), DATA_W'($urandom),
               be, bw, ADDR_W'($urandom_range(0, 7)), DATA_W'($urandom));
    end
    idle("R8"); idle("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule